// File: doc/BRIEF.md
# Bit-Pair Addressed Select Receiver

This block watches a serial test data line, sampled once per rising edge of the test clock. It looks for an address frame made of two-bit line-code symbols. The four symbols are idle, select, data-one and data-zero. The receiver finds where a frame starts and checks the framing symbols around the address. It gathers ten address bits and compares them with a static 10-bit device address. When the frame is complete and the address agrees, it raises a one-cycle match pulse. Downstream logic uses that pulse to start an acknowledge reply.

A frame counts only if the test-access controller stays in one of four quiet states for the whole frame. A change of controller state, or any movement on the mode line, throws away the frame in progress. A line that nobody drives is pulled high, so it looks like a run of idle symbols.

Top module: `bpsel_rx`

## Requirements
- R1: Bits are grouped into pairs once a frame is aligned. The first bit of a pair is the one sampled earlier. The pairs decode as follows: 1 then 1 is idle, 0 then 0 is select, 0 then 1 is a data one, and 1 then 0 is a data zero.
- R2: A frame is accepted only when it has this exact shape: idle, select, ten data pairs, select, idle.
- R3: Frames are received only while `tapState` holds one of four codes: 4'hF (reset), 4'hC (run/idle), 4'h3 (pause on the data path) or 4'hB (pause on the instruction path). Any other code, including the shift codes 4'h2 and 4'hA, prevents any pulse.
- R4: `modeIn` may sit at either level, but it must not change during a frame. A change aborts the frame and no pulse follows.
- R5: A change of `tapState` during a frame aborts it, even when both the old and the new code are quiet states.
- R6: `selMatch` pulses only when all ten received bits equal `devAddr`.
- R7: The first data pair carries bit 0 of the address and the last data pair carries bit 9.
- R8: Alignment starts at the first point where an idle pair is followed by a select pair. Any number of high bits, odd or even, may come before it. A line held high never produces a pulse.
- R9: `selMatch` is high for exactly one cycle. That cycle is the one that follows the clock edge sampling the second bit of the closing idle.
- R10: The frame is dropped with no pulse in three cases: a select or idle pair where a data pair belongs, a non-select pair where the closing select belongs, or a non-idle pair where the closing idle belongs.
- R11: While `rst` is high at a clock edge, the receiver returns to searching for a frame and forgets any frame in progress. `selMatch` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial test data line (pulled high when undriven) |
| modeIn | input | 1 | Mode-select line; must stay constant during a frame |
| tapState | input | 4 | Current state code of the test-access controller |
| devAddr | input | 10 | Static address of this device |
| selMatch | output | 1 | One-cycle pulse on a complete frame whose address matches |

## Verification
The bench sends all 1024 addresses against one device address. A comparator that checked only some of the bits would pulse more than once in that sweep, and a receiver that took the bits MSB first would fire on the bit-reversed address. It tries every `tapState` code with an otherwise valid frame, so a receiver that ignored the gating would pulse in the shift states. It also aborts frames mid-way by moving the mode line, by stepping between two quiet controller states and by a reset. A receiver that compared only the start and end conditions would pass those frames through. The remaining cases are frames with a broken data pair, a broken closing select or a broken closing idle, and frames preceded by an odd number of idle bits. A receiver with lax framing would accept the broken frames, and one that paired bits from the first high bit would miss the odd-count frames.

// File: rtl/bpsel_pkg.sv
`timescale 1ns/1ps
package bpsel_pkg;

  localparam int TAP_W = 4;

  localparam logic [TAP_W-1:0] TAP_RESET    = 4'hF;
  localparam logic [TAP_W-1:0] TAP_IDLE     = 4'hC;
  localparam logic [TAP_W-1:0] TAP_PAUSE_DR = 4'h3;
  localparam logic [TAP_W-1:0] TAP_PAUSE_IR = 4'hB;

  // symbol code is {earlier bit, later bit}
  typedef enum logic [1:0] {
    SYM_SEL   = 2'b00,
    SYM_DATA1 = 2'b01,
    SYM_DATA0 = 2'b10,
    SYM_IDLE  = 2'b11
  } sym_e;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_DATA,
    ST_CSEL,
    ST_CIDLE
  } st_e;

  typedef struct packed {
    logic clrHist;
    logic takeFirst;
    logic shiftBit;
    logic clrAddr;
  } strobe_t;

  function automatic logic tapQuiet(input logic [TAP_W-1:0] s);
    return (s == TAP_RESET) || (s == TAP_IDLE) ||
           (s == TAP_PAUSE_DR) || (s == TAP_PAUSE_IR);
  endfunction

endpackage

// File: rtl/bpsel_dp.sv
`timescale 1ns/1ps
module bpsel_dp
  import bpsel_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serialIn,
  input  logic                modeIn,
  input  logic [TAP_W-1:0]    tapState,
  input  logic [ADDR_W-1:0]   devAddr,
  input  strobe_t             strb,
  output sym_e                sym,
  output logic                openSeen,
  output logic                disrupt,
  output logic                addrEq
);

  localparam int HIST_W = 3;

  logic [HIST_W-1:0] hist;
  logic              firstBit;
  logic [ADDR_W-1:0] rxAddr;
  logic [TAP_W-1:0]  prevTap;
  logic              prevMode;
  logic              primed;

  // pair formed by the stored first bit and the bit on the line now
  assign sym = sym_e'({firstBit, serialIn});

  // idle pair followed by select pair, ending with the current sample
  assign openSeen = ({hist, serialIn} == {2'b11, 2'b00});

  assign disrupt = !tapQuiet(tapState) ||
                   (primed && ((tapState != prevTap) || (modeIn != prevMode)));

  assign addrEq = (rxAddr == devAddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      firstBit <= 1'b0;
      rxAddr   <= '0;
      prevTap  <= '0;
      prevMode <= 1'b0;
      primed   <= 1'b0;
    end else begin
      primed   <= 1'b1;
      prevTap  <= tapState;
      prevMode <= modeIn;
      if (strb.clrHist) hist <= '0;
      else              hist <= {hist[HIST_W-2:0], serialIn};
      if (strb.takeFirst) firstBit <= serialIn;
      if (strb.clrAddr)       rxAddr <= '0;
      else if (strb.shiftBit) rxAddr <= {(sym == SYM_DATA1), rxAddr[ADDR_W-1:1]};
    end
  end

endmodule

// File: rtl/bpsel_ctl.sv
`timescale 1ns/1ps
module bpsel_ctl
  import bpsel_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  sym_e    sym,
  input  logic    openSeen,
  input  logic    disrupt,
  input  logic    addrEq,
  output strobe_t strb,
  output logic    selMatch
);

  localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);

  st_e              st, stNxt;
  logic             half, halfNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             fire;
  logic             isData;

  assign isData = (sym == SYM_DATA0) || (sym == SYM_DATA1);

  always_comb begin
    stNxt   = st;
    halfNxt = half;
    cntNxt  = cnt;
    strb    = '0;
    fire    = 1'b0;
    if (disrupt) begin
      strb.clrHist = 1'b1;
      stNxt        = ST_HUNT;
      halfNxt      = 1'b0;
    end else if (st == ST_HUNT) begin
      if (openSeen) begin
        stNxt        = ST_DATA;
        halfNxt      = 1'b0;
        cntNxt       = '0;
        strb.clrAddr = 1'b1;
      end
    end else if (!half) begin
      strb.takeFirst = 1'b1;
      halfNxt        = 1'b1;
    end else begin
      halfNxt = 1'b0;
      unique case (st)
        ST_DATA: begin
          if (isData) begin
            strb.shiftBit = 1'b1;
            if (cnt == LAST_IDX) stNxt = ST_CSEL;
            else                 cntNxt = cnt + 1'b1;
          end else begin
            stNxt = ST_HUNT;
          end
        end
        ST_CSEL:  stNxt = (sym == SYM_SEL) ? ST_CIDLE : ST_HUNT;
        ST_CIDLE: begin
          stNxt = ST_HUNT;
          fire  = (sym == SYM_IDLE);
        end
        default:  stNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      half     <= 1'b0;
      cnt      <= '0;
      selMatch <= 1'b0;
    end else begin
      st       <= stNxt;
      half     <= halfNxt;
      cnt      <= cntNxt;
      selMatch <= fire && addrEq;
    end
  end

endmodule

// File: rtl/bpsel_rx.sv
`timescale 1ns/1ps
module bpsel_rx
  import bpsel_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              modeIn,
  input  logic [3:0]        tapState,
  input  logic [ADDR_W-1:0] devAddr,
  output logic              selMatch
);

  strobe_t strb;
  sym_e    sym;
  logic    openSeen;
  logic    disrupt;
  logic    addrEq;

  bpsel_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .modeIn   (modeIn),
    .tapState (tapState),
    .devAddr  (devAddr),
    .strb     (strb),
    .sym      (sym),
    .openSeen (openSeen),
    .disrupt  (disrupt),
    .addrEq   (addrEq)
  );

  bpsel_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .sym      (sym),
    .openSeen (openSeen),
    .disrupt  (disrupt),
    .addrEq   (addrEq),
    .strb     (strb),
    .selMatch (selMatch)
  );

endmodule

// File: rtl/bpsel_rx_chk.sv
`timescale 1ns/1ps
module bpsel_rx_chk
  import bpsel_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              serialIn,
  input logic              modeIn,
  input logic [3:0]        tapState,
  input logic [ADDR_W-1:0] devAddr,
  input logic              selMatch,
  input logic [ADDR_W-1:0] rxAddr
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    selMatch |=> !selMatch);

  a_r3_quiet_only: assert property (@(posedge clk) disable iff (rst)
    !tapQuiet(tapState) |=> !selMatch);

  a_r4_mode_steady: assert property (@(posedge clk) disable iff (rst)
    (modeIn != $past(modeIn)) |=> !selMatch);

  a_r2_closing_idle: assert property (@(posedge clk) disable iff (rst)
    selMatch |-> ($past(serialIn) && $past(serialIn, 2)));

  a_r6_addr_equal: assert property (@(posedge clk) disable iff (rst)
    selMatch |-> (rxAddr == $past(devAddr)));

endmodule

bind bpsel_rx bpsel_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .modeIn   (modeIn),
  .tapState (tapState),
  .devAddr  (devAddr),
  .selMatch (selMatch),
  .rxAddr   (u_dp.rxAddr)
);

// File: tb/bpsel_rx_tb.sv
`timescale 1ns/1ps
module bpsel_rx_tb;

  localparam int FRM_LEN = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b1;
  logic       modeIn = 1'b0;
  logic [3:0] tapState = 4'hC;
  logic [9:0] devAddr = '0;
  logic       selMatch;

  int nChecks = 0;
  int nFail = 0;

  logic frm [FRM_LEN];
  logic [3:0] frameTap = 4'hC;
  logic       frameMode = 1'b0;
  int         evtIdx = -1;
  int         evtKind = 0;

  always #4 clk = ~clk;

  bpsel_rx u_dut (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .modeIn   (modeIn),
    .tapState (tapState),
    .devAddr  (devAddr),
    .selMatch (selMatch)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    @(negedge clk);
    serialIn = b;
  endtask

  // data one is 0 then 1, data zero is 1 then 0, LSB first
  task automatic buildFrame(input logic [9:0] a);
    frm[0] = 1'b1; frm[1] = 1'b1; frm[2] = 1'b0; frm[3] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      frm[4 + 2*k] = !a[k];
      frm[5 + 2*k] = a[k];
    end
    frm[24] = 1'b0; frm[25] = 1'b0;
    frm[26] = 1'b1; frm[27] = 1'b1;
  endtask

  task automatic sendAndCheck(input string req, input logic expP);
    @(negedge clk);
    serialIn = 1'b1;
    tapState = frameTap;
    modeIn   = frameMode;
    for (int i = 0; i < 3; i++) bitOut(1'b1);
    for (int i = 0; i < FRM_LEN; i++) begin
      @(negedge clk);
      serialIn = frm[i];
      if (evtKind == 3 && i == evtIdx + 1) rst = 1'b0;
      if (i == evtIdx) begin
        case (evtKind)
          1: modeIn = !modeIn;
          2: tapState = 4'h3;
          3: rst = 1'b1;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(req, int'(selMatch), int'(expP));
    serialIn = 1'b1;
    @(negedge clk);
    chk({req, " R9 one cycle"}, int'(selMatch), 0);
    evtIdx  = -1;
    evtKind = 0;
  endtask

  initial begin
    #(8ns * 200000);
    nFail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", int'(selMatch), 0);
    rst = 1'b0;

    // R8: idle line never pulses
    for (int i = 0; i < 40; i++) begin
      bitOut(1'b1);
      chk("R8 idle line", int'(selMatch), 0);
    end

    // R6 R7 R1 R2: full address sweep against one device address
    devAddr = 10'h2A5;
    for (int v = 0; v < 1024; v++) begin
      buildFrame(10'(v));
      sendAndCheck("R6 R1 R2 sweep", (v == 10'h2A5));
    end
    buildFrame(10'h295);
    sendAndCheck("R7 reversed order", 1'b0);
    buildFrame(10'h2A5);
    sendAndCheck("R7 lsb first", 1'b1);

    // R3: every controller state code
    devAddr = 10'h000;
    buildFrame(10'h000);
    for (int t = 0; t < 16; t++) begin
      frameTap = 4'(t);
      sendAndCheck("R3 state gate", (t == 15) || (t == 12) || (t == 3) || (t == 11));
    end
    frameTap = 4'hC;

    // R4: either steady level works, a toggle aborts
    frameMode = 1'b1;
    sendAndCheck("R4 mode high", 1'b1);
    frameMode = 1'b0;
    sendAndCheck("R4 mode low", 1'b1);
    evtIdx = 12; evtKind = 1;
    sendAndCheck("R4 mode toggle", 1'b0);

    // R5: move between two quiet states mid-frame
    evtIdx = 10; evtKind = 2;
    sendAndCheck("R5 state change", 1'b0);
    frameTap = 4'h3;
    sendAndCheck("R5 steady pause", 1'b1);
    frameTap = 4'hC;

    // R10: broken framing
    buildFrame(10'h000);
    frm[10] = 1'b0; frm[11] = 1'b0;
    sendAndCheck("R10 select in data", 1'b0);
    buildFrame(10'h000);
    frm[10] = 1'b1; frm[11] = 1'b1;
    sendAndCheck("R10 idle in data", 1'b0);
    buildFrame(10'h000);
    frm[24] = 1'b1; frm[25] = 1'b1;
    sendAndCheck("R10 no closing select", 1'b0);
    buildFrame(10'h000);
    frm[26] = 1'b0; frm[27] = 1'b0;
    sendAndCheck("R10 no closing idle", 1'b0);

    // R8: odd run of idle bits ahead of the frame
    buildFrame(10'h000);
    bitOut(1'b0);
    bitOut(1'b1);
    sendAndCheck("R8 odd preamble", 1'b1);

    // R11: reset in the middle of a frame
    evtIdx = 14; evtKind = 3;
    sendAndCheck("R11 reset mid-frame", 1'b0);
    sendAndCheck("R11 after reset", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule